// File: doc/BRIEF.md
# Gated Carrier Divider Timer

This block divides a slow external carrier by a programmable period. A 16-bit up-counter advances once for each rising edge of the carrier, which is sampled in the system clock domain. It returns to zero after it reaches the period value. Two waveform outputs are derived from the count. Output A rises at one compare value and falls at the period value. Output B rises on an external event edge and falls at a second compare value. A gate input can hold the counter still while gating mode is on. A software trigger restarts the count and drops both outputs.

The period can be changed while the counter runs. If the running count is already above the new period, a retrigger controller keeps the count running. It then restarts the counter at the first system cycle where the count is an exact multiple of the new period, so the divided waveform keeps its phase. When gating mode is on and the gate is low at the moment of the write, no restart is scheduled, because the counter is frozen.

The block has no data stream. All pins are plain control and status signals without a handshake. Register writes are single-cycle strobes in the system clock domain.

Top module: `carrier_div_timer`

## Requirements
- R1: Each carrier tick (a 0-to-1 change of `carrier_in` between two system cycles) that is allowed to count moves `cnt_o` to 0 if it equals the period register, otherwise to `cnt_o`+1. One period therefore spans period+1 ticks. The new value is visible one system cycle after the tick is sampled.
- R2: `out_a` goes high on a tick that moves the count onto the A-compare value. It goes low on a tick that moves the count onto the period value. If both happen at once, low wins.
- R3: `out_b` goes high in the cycle after `evt_in` is first seen high after being low. It goes low on a tick that moves the count onto the B-compare value, and this clear wins over a simultaneous event.
- R4: A cycle with `sw_trig` high makes `cnt_o` zero and both outputs low on the next cycle. This overrides counting, compares and events.
- R5: With `gate_en` high, a tick advances the counter only if `gate_in` is high in the same cycle. With `gate_en` low, `gate_in` has no effect.
- R6: A period write whose value is below the current count schedules a restart. The counter keeps advancing, and in the first cycle where count mod new period is zero, the block clears the count and both outputs on the next edge. A write at or above the current count schedules nothing.
- R7: If `gate_en` is high and `gate_in` is low during a period write, no restart is scheduled, even when the count exceeds the new value.
- R8: After reset, `cnt_o` is 0, both outputs are low, and the period register holds 128, so the count reaches 128 before it wraps.
- R9: With `wr_en` high, `wr_data` is loaded into one register chosen by `wr_sel`: 0 is the A-compare, 1 is the B-compare, 2 is the period, and 3 selects nothing. A write takes effect on the next edge.
- R10: An `evt_in` held high sets `out_b` only once. After a B-compare clears it, `out_b` stays low until `evt_in` falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| carrier_in | input | 1 | Carrier level; each rising edge is one tick |
| gate_en | input | 1 | Enables gating of the counter by `gate_in` |
| gate_in | input | 1 | Gate level; counting allowed while high |
| evt_in | input | 1 | External event level; a rising edge sets `out_b` |
| sw_trig | input | 1 | Software restart strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 A-compare, 1 B-compare, 2 period |
| wr_data | input | CNT_W | Write value |
| out_a | output | 1 | Waveform output A |
| out_b | output | 1 | Waveform output B |
| cnt_o | output | CNT_W | Current count |

## Verification
The assertions check, on every cycle, the following properties:
- The count only ever steps by one or drops to zero.
- A software or scheduled restart leaves zero and low outputs.
- A gated tick leaves the count unchanged.
- `out_a` only rises onto the A-compare value, and `out_b` only rises after an event edge.
- A restart is only scheduled when the count was above the written period.

Only the bench scenarios can show the following:
- The A duty cycle across a sweep of periods and compare values.
- The exact tick on which a phase-preserving restart lands.
- Restarts being skipped while the gate is low.
- An event held high causing only one set.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  typedef enum logic [1:0] {
    SEL_CMP_A  = 2'd0,
    SEL_CMP_B  = 2'd1,
    SEL_PERIOD = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/rise_detect.sv
module rise_detect #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig,
  output logic [W-1:0] rise
);
  logic [W-1:0] sig_d;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) sig_d[i] <= 1'b0;
      else        sig_d[i] <= sig[i];
    end
    assign rise[i] = sig[i] & ~sig_d[i];
  end
endmodule

// File: rtl/cdiv_core.sv
module cdiv_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic             evt_rise,
  input  logic             restart,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             wave_a,
  output logic             wave_b
);
  logic [CNT_W-1:0] cnt_next;

  // value entered by the next tick: wrap after the period value
  always_comb cnt_next = (cnt == period) ? '0 : cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cnt    <= '0;
      wave_a <= 1'b0;
      wave_b <= 1'b0;
    end else begin
      if (advance) cnt <= cnt_next;

      if (advance && cnt_next == period)     wave_a <= 1'b0;
      else if (advance && cnt_next == cmp_a) wave_a <= 1'b1;

      if (advance && cnt_next == cmp_b) wave_b <= 1'b0;
      else if (evt_rise)                wave_b <= 1'b1;
    end
  end
endmodule

// File: rtl/cdiv_retrig.sv
module cdiv_retrig #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             period_wr,
  input  logic [CNT_W-1:0] period_new,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] cnt,
  input  logic             counter_frozen,
  input  logic             sw_trig,
  output logic             pend,
  output logic             fire
);
  logic aligned;

  // a zero period is treated as aligning only at count zero
  always_comb begin
    if (period == '0) aligned = (cnt == '0);
    else              aligned = ((cnt % period) == '0);
  end

  assign fire = pend & aligned;

  always_ff @(posedge clk) begin
    if (!rst_n || sw_trig) pend <= 1'b0;
    else if (period_wr)    pend <= (cnt > period_new) && !counter_frozen;
    else if (fire)         pend <= 1'b0;
  end
endmodule

// File: rtl/carrier_div_timer.sv
module carrier_div_timer #(
  parameter int CNT_W        = 16,
  parameter int RESET_PERIOD = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             carrier_in,
  input  logic             gate_en,
  input  logic             gate_in,
  input  logic             evt_in,
  input  logic             sw_trig,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic             out_a,
  output logic             out_b,
  output logic [CNT_W-1:0] cnt_o
);
  import cdiv_pkg::*;

  localparam logic [CNT_W-1:0] PERIOD_INIT = CNT_W'(RESET_PERIOD);
  localparam logic [CNT_W-1:0] CMPA_INIT   = CNT_W'(RESET_PERIOD / 2);
  localparam logic [CNT_W-1:0] CMPB_INIT   = CNT_W'(RESET_PERIOD / 4);

  logic [CNT_W-1:0] cmp_a_q, cmp_b_q, period_q;
  logic [1:0]       edges;
  logic             car_rise, evt_rise, advance, frozen, pend_q, fire, restart;
  reg_sel_e         sel;

  assign sel = reg_sel_e'(wr_sel);

  rise_detect #(.W(2)) u_edges (
    .clk  (clk),
    .rst_n(rst_n),
    .sig  ({evt_in, carrier_in}),
    .rise (edges)
  );
  assign car_rise = edges[0];
  assign evt_rise = edges[1];

  assign frozen  = gate_en & ~gate_in;
  assign advance = car_rise & ~frozen;
  assign restart = sw_trig | fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_a_q  <= CMPA_INIT;
      cmp_b_q  <= CMPB_INIT;
      period_q <= PERIOD_INIT;
    end else if (wr_en) begin
      case (sel)
        SEL_CMP_A:  cmp_a_q  <= wr_data;
        SEL_CMP_B:  cmp_b_q  <= wr_data;
        SEL_PERIOD: period_q <= wr_data;
        default:    ;
      endcase
    end
  end

  cdiv_retrig #(.CNT_W(CNT_W)) u_retrig (
    .clk           (clk),
    .rst_n         (rst_n),
    .period_wr     (wr_en && sel == SEL_PERIOD),
    .period_new    (wr_data),
    .period        (period_q),
    .cnt           (cnt_o),
    .counter_frozen(frozen),
    .sw_trig       (sw_trig),
    .pend          (pend_q),
    .fire          (fire)
  );

  cdiv_core #(.CNT_W(CNT_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (advance),
    .evt_rise(evt_rise),
    .restart (restart),
    .cmp_a   (cmp_a_q),
    .cmp_b   (cmp_b_q),
    .period  (period_q),
    .cnt     (cnt_o),
    .wave_a  (out_a),
    .wave_b  (out_b)
  );
endmodule

// File: rtl/cdiv_checks.sv
module cdiv_checks #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_trig,
  input logic             gate_en,
  input logic             gate_in,
  input logic             evt_rise,
  input logic             fire,
  input logic             pend_q,
  input logic [CNT_W-1:0] cmp_a_q,
  input logic [CNT_W-1:0] period_q,
  input logic [CNT_W-1:0] cnt_o,
  input logic             out_a,
  input logic             out_b
);
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_o) |-> (cnt_o == '0 || cnt_o == CNT_W'($past(cnt_o) + 1'b1))); // R1

  AST_A_RISE_AT_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_a) |-> cnt_o == $past(cmp_a_q)); // R2

  AST_B_RISE_ON_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_b) |-> $past(evt_rise)); // R3

  AST_SWTRIG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_trig |=> (cnt_o == '0 && !out_a && !out_b)); // R4

  AST_GATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && !gate_in && !sw_trig && !fire) |=> $stable(cnt_o)); // R5

  AST_PEND_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(cnt_o) > period_q); // R6

  AST_FIRE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cnt_o == '0 && !out_a && !out_b)); // R6
endmodule

bind carrier_div_timer cdiv_checks #(.CNT_W(CNT_W)) u_checks (
  .clk     (clk),
  .rst_n   (rst_n),
  .sw_trig (sw_trig),
  .gate_en (gate_en),
  .gate_in (gate_in),
  .evt_rise(evt_rise),
  .fire    (fire),
  .pend_q  (pend_q),
  .cmp_a_q (cmp_a_q),
  .period_q(period_q),
  .cnt_o   (cnt_o),
  .out_a   (out_a),
  .out_b   (out_b)
);

// File: tb/carrier_div_timer_tb_top.sv
module carrier_div_timer_tb_top;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic carrier_in = 1'b0, gate_en = 1'b0, gate_in = 1'b0, evt_in = 1'b0;
  logic sw_trig = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd3;
  logic [CNT_W-1:0] wr_data = '0;
  logic out_a, out_b;
  logic [CNT_W-1:0] cnt_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  carrier_div_timer #(.CNT_W(CNT_W), .RESET_PERIOD(128)) dut_i (
    .clk(clk), .rst_n(rst_n), .carrier_in(carrier_in), .gate_en(gate_en),
    .gate_in(gate_in), .evt_in(evt_in), .sw_trig(sw_trig), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .out_a(out_a), .out_b(out_b), .cnt_o(cnt_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input int val);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = CNT_W'(val);
    @(negedge clk); wr_en = 1'b0; wr_sel = 2'd3;
  endtask

  task automatic trig();
    @(negedge clk); sw_trig = 1'b1;
    @(negedge clk); sw_trig = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); carrier_in = 1'b1;
      @(negedge clk); carrier_in = 1'b0;
    end
  endtask

  task automatic evt_pulse();
    @(negedge clk); evt_in = 1'b1;
    @(negedge clk); evt_in = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state and default period of 128
    check("R8 cnt", int'(cnt_o), 0);
    check("R8 out_a", int'(out_a), 0);
    check("R8 out_b", int'(out_b), 0);
    tick(128);
    check("R8 count reaches 128", int'(cnt_o), 128);
    tick(1);
    check("R8 wrap after 128", int'(cnt_o), 0);

    // R1 R2 R9 sweep of small periods and A-compare values
    wr(2'd1, 200);
    for (int rc = 3; rc <= 7; rc++) begin
      for (int ra = 1; ra < rc; ra++) begin
        wr(2'd0, ra);
        wr(2'd2, rc);
        trig();
        for (int k = 1; k <= 2 * (rc + 1); k++) begin
          int c;
          tick(1);
          c = k % (rc + 1);
          check("R1 count", int'(cnt_o), c);
          check("R2 out_a", int'(out_a), (c >= ra && c < rc) ? 1 : 0);
        end
      end
    end

    // R2 equal compares: clear wins, A never rises
    wr(2'd0, 4); wr(2'd2, 4); trig();
    tick(5);
    check("R2 equal cmp keeps A low", int'(out_a), 0);

    // R3 event sets B, B-compare clears it
    wr(2'd2, 20); wr(2'd1, 10); wr(2'd0, 2); trig();
    tick(3);
    check("R3 B low before event", int'(out_b), 0);
    evt_pulse();
    check("R3 B set by event", int'(out_b), 1);
    tick(6);
    check("R3 B held at count 9", int'(out_b), 1);
    tick(1);
    check("R3 B cleared at cmp", int'(out_b), 0);

    // R10 held event sets only once
    @(negedge clk); evt_in = 1'b1;
    @(negedge clk);
    check("R10 held event sets B", int'(out_b), 1);
    tick(21);
    check("R10 count back at 10", int'(cnt_o), 10);
    check("R10 B cleared with event held", int'(out_b), 0);
    tick(1);
    check("R10 no re-set while held", int'(out_b), 0);
    @(negedge clk); evt_in = 1'b0;

    // R4 software trigger clears everything
    trig();
    tick(5);
    evt_pulse();
    check("R4 A high before trig", int'(out_a), 1);
    check("R4 B high before trig", int'(out_b), 1);
    trig();
    check("R4 cnt cleared", int'(cnt_o), 0);
    check("R4 A cleared", int'(out_a), 0);
    check("R4 B cleared", int'(out_b), 0);

    // R5 gating
    wr(2'd2, 128);
    gate_en = 1'b1; gate_in = 1'b0;
    trig();
    tick(5);
    check("R5 gated count frozen", int'(cnt_o), 0);
    gate_in = 1'b1;
    tick(3);
    check("R5 gate open counts", int'(cnt_o), 3);
    gate_en = 1'b0; gate_in = 1'b0;
    tick(3);
    check("R5 gate ignored when disabled", int'(cnt_o), 6);

    // R6 restart waits for a multiple of the new period
    trig();
    tick(50);
    wr(2'd2, 8);
    tick(5);
    check("R6 still running at 55", int'(cnt_o), 55);
    tick(1);
    check("R6 reaches 56", int'(cnt_o), 56);
    @(negedge clk);
    check("R6 restart at multiple", int'(cnt_o), 0);
    tick(4);
    check("R6 phase kept, new period", int'(cnt_o), 4);
    tick(5);
    check("R6 wraps at new period", int'(cnt_o), 0);

    // R6 count already a multiple: immediate restart
    wr(2'd2, 128); trig();
    tick(48);
    wr(2'd2, 8);
    @(negedge clk);
    check("R6 immediate restart", int'(cnt_o), 0);

    // R6 write above count schedules nothing
    wr(2'd2, 128); trig();
    tick(5);
    wr(2'd2, 8);
    repeat (3) @(negedge clk);
    check("R6 no restart below period", int'(cnt_o), 5);

    // R7 gate low during write skips the restart
    wr(2'd2, 128);
    gate_en = 1'b1; gate_in = 1'b1;
    trig();
    tick(30);
    gate_in = 1'b0;
    wr(2'd2, 4);
    gate_in = 1'b1;
    tick(2);
    check("R7 count reaches 32", int'(cnt_o), 32);
    repeat (2) @(negedge clk);
    check("R7 no restart scheduled", int'(cnt_o), 32);
    tick(1);
    check("R7 keeps counting", int'(cnt_o), 33);
    gate_en = 1'b0;
    trig();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule